// File: doc/BRIEF.md
# Fractional UART Baud Clock Generator

This block derives the bit timing of a 16550-compatible serial port from a fixed crystal clock. Three programmable stages run in series. A fractional stage adds a multiplier to an accumulator on every crystal cycle. Each time the sum reaches the divisor, it emits a one-cycle UART clock enable. A prescaler divides that enable into the oversample tick. The 16-bit divisor latch value supplied by the serial core divides the oversample tick again to form the baud tick.

Software programs the multiplier, divisor and prescale through three 32-bit registers on a simple read/write bus. The address of each register is its index shifted left by a register-shift parameter, plus a base offset. The reset values are multiplier 96, divisor 125 and prescale 16. With a divisor latch of 16, these turn a 38.4 MHz crystal into a 29.4912 MHz average UART clock and a 115200 Hz baud tick, with no setup needed.

Top module: `frac_baud_gen`

## Requirements
- R1: Over any run of `div` consecutive crystal cycles, `frac_en` is high for exactly `mul` of them, provided 0 < `mul` <= `div` and no register is written.
- R2: `os_tick` pulses once for every `ps` pulses of `frac_en`, one cycle after the enable that completes the count. `baud_tick` pulses once for every `dl_value` pulses of `os_tick`, one cycle after the completing tick. With defaults and `dl_value`=16, every 2000 cycles carry 1536 enables, 96 oversample ticks and 6 baud ticks.
- R3: The prescale, multiplier and divisor registers sit at bus indices 0x30, 0x34 and 0x38. The address of each is `BASE_OFS + (index << REG_SHIFT)`. A read returns the stored value on `bus_rdata` one cycle after `bus_rd`.
- R4: After reset, the registers read prescale 16, multiplier 96 and divisor 125, and all three pulse outputs are low.
- R5: If the multiplier is 0, or greater than the divisor, `cfg_err` goes high one cycle after the write and `frac_en`, `os_tick` and `baud_tick` stay low.
- R6: When the multiplier equals the divisor, `frac_en` is high on every cycle.
- R7: A write to any of the three registers clears the accumulator and both counters. All pulse outputs are low in the cycle after the write edge, and with multiplier 96 and divisor 125 the first enable follows two cycles after that edge.
- R8: A prescale value of 0 acts as 1, and a `dl_value` of 0 acts as 1.
- R9: A read at any address other than the three register addresses returns 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Crystal clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe |
| bus_addr | input | ADDR_W | Register byte address |
| bus_wdata | input | DATA_W | Write data |
| bus_rdata | output | DATA_W | Read data, valid one cycle after `bus_rd` |
| dl_value | input | LATCH_W | Divisor latch value from the serial core |
| frac_en | output | 1 | Fractional UART clock enable |
| os_tick | output | 1 | Oversample tick after the prescaler |
| baud_tick | output | 1 | Baud tick after the divisor latch |
| cfg_err | output | 1 | Multiplier is zero or exceeds the divisor |

## Verification
The case that is hardest to reach from the ports is the clear on a register write. It must hold whatever the accumulator phase is at the moment of the write, but the ports never show that phase. The stimulus rewrites the prescale register with its current value after waiting a different number of cycles each time, so the write lands at several different phases. For each write it checks that the first enable arrives exactly two cycles after the write edge. The rates are measured over windows equal to one full period of the combined counter pattern, so each expected count is exact and never rounded.

// File: rtl/fbg_pkg.sv
package fbg_pkg;
  localparam int NREG = 3;

  // Register slots: 0 prescale, 1 multiplier, 2 divisor
  localparam int SLOT_PS  = 0;
  localparam int SLOT_MUL = 1;
  localparam int SLOT_DIV = 2;

  // Unscaled bus index of a register slot
  function automatic int unsigned slot_index(int unsigned slot);
    return 32'h30 + 4 * slot;
  endfunction

  // Scaled bus address of a register slot
  function automatic int unsigned slot_addr(int unsigned slot, int unsigned shift,
                                            int unsigned base);
    return base + (slot_index(slot) << shift);
  endfunction
endpackage

// File: rtl/fbg_regs.sv
module fbg_regs
  import fbg_pkg::*;
#(
  parameter int DATA_W    = 32,
  parameter int ADDR_W    = 8,
  parameter int REG_SHIFT = 0,
  parameter int BASE_OFS  = 0,
  parameter int PS_RST    = 16,
  parameter int MUL_RST   = 96,
  parameter int DIV_RST   = 125
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata,
  output logic [DATA_W-1:0] ps_val,
  output logic [DATA_W-1:0] mul_val,
  output logic [DATA_W-1:0] div_val,
  output logic              cfg_wr
);
  logic [NREG-1:0]             hit;
  logic [NREG-1:0][DATA_W-1:0] bank;
  logic [DATA_W-1:0]           rd_mux;

  for (genvar g = 0; g < NREG; g++) begin : g_slot
    localparam logic [ADDR_W-1:0] OFS =
      ADDR_W'(slot_addr(g, REG_SHIFT, BASE_OFS));
    localparam logic [DATA_W-1:0] RSTV =
      (g == SLOT_PS)  ? DATA_W'(PS_RST)  :
      (g == SLOT_MUL) ? DATA_W'(MUL_RST) : DATA_W'(DIV_RST);
    logic [DATA_W-1:0] q;

    assign hit[g] = (addr == OFS);

    always_ff @(posedge clk) begin
      if (rst)                 q <= RSTV;
      else if (wr_en && hit[g]) q <= wdata;
    end

    assign bank[g] = q;
  end

  always_comb begin
    rd_mux = '0;
    for (int i = 0; i < NREG; i++) begin
      if (hit[i]) rd_mux = rd_mux | bank[i];
    end
  end

  always_ff @(posedge clk) begin
    if (rst)        rdata <= '0;
    else if (rd_en) rdata <= rd_mux;
  end

  assign ps_val  = bank[SLOT_PS];
  assign mul_val = bank[SLOT_MUL];
  assign div_val = bank[SLOT_DIV];
  assign cfg_wr  = wr_en && (|hit);
endmodule

// File: rtl/fbg_frac_acc.sv
module fbg_frac_acc #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         clr,
  input  logic [W-1:0] mul,
  input  logic [W-1:0] div,
  output logic         frac_en,
  output logic         cfg_err
);
  logic [W:0] acc_q;
  logic [W:0] sum;
  logic       cfg_bad;

  assign cfg_bad = (mul == '0) || (mul > div);
  assign sum     = acc_q + {1'b0, mul};

  always_ff @(posedge clk) begin
    if (rst || clr || cfg_bad) begin
      acc_q   <= '0;
      frac_en <= 1'b0;
    end else if (sum >= {1'b0, div}) begin
      acc_q   <= sum - {1'b0, div};
      frac_en <= 1'b1;
    end else begin
      acc_q   <= sum;
      frac_en <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) cfg_err <= 1'b0;
    else     cfg_err <= cfg_bad;
  end
endmodule

// File: rtl/fbg_pulse_div.sv
module fbg_pulse_div #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         clr,
  input  logic         pulse_in,
  input  logic [W-1:0] limit,
  output logic         pulse_out
);
  logic [W-1:0] cnt_q;
  logic [W-1:0] last;

  // A limit of zero behaves like a limit of one
  assign last = (limit == '0) ? '0 : limit - 1'b1;

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      cnt_q     <= '0;
      pulse_out <= 1'b0;
    end else begin
      pulse_out <= 1'b0;
      if (pulse_in) begin
        if (cnt_q >= last) begin
          cnt_q     <= '0;
          pulse_out <= 1'b1;
        end else begin
          cnt_q <= cnt_q + 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/frac_baud_gen.sv
module frac_baud_gen #(
  parameter int DATA_W    = 32,
  parameter int ADDR_W    = 8,
  parameter int LATCH_W   = 16,
  parameter int REG_SHIFT = 0,
  parameter int BASE_OFS  = 0,
  parameter int PS_RST    = 16,
  parameter int MUL_RST   = 96,
  parameter int DIV_RST   = 125
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               bus_wr,
  input  logic               bus_rd,
  input  logic [ADDR_W-1:0]  bus_addr,
  input  logic [DATA_W-1:0]  bus_wdata,
  output logic [DATA_W-1:0]  bus_rdata,
  input  logic [LATCH_W-1:0] dl_value,
  output logic               frac_en,
  output logic               os_tick,
  output logic               baud_tick,
  output logic               cfg_err
);
  logic [DATA_W-1:0] ps_val, mul_val, div_val;
  logic              cfg_wr;

  fbg_regs #(
    .DATA_W(DATA_W), .ADDR_W(ADDR_W), .REG_SHIFT(REG_SHIFT),
    .BASE_OFS(BASE_OFS), .PS_RST(PS_RST), .MUL_RST(MUL_RST), .DIV_RST(DIV_RST)
  ) u_regs (
    .clk(clk), .rst(rst), .wr_en(bus_wr), .rd_en(bus_rd), .addr(bus_addr),
    .wdata(bus_wdata), .rdata(bus_rdata), .ps_val(ps_val), .mul_val(mul_val),
    .div_val(div_val), .cfg_wr(cfg_wr)
  );

  fbg_frac_acc #(.W(DATA_W)) u_frac (
    .clk(clk), .rst(rst), .clr(cfg_wr), .mul(mul_val), .div(div_val),
    .frac_en(frac_en), .cfg_err(cfg_err)
  );

  fbg_pulse_div #(.W(DATA_W)) u_prescale (
    .clk(clk), .rst(rst), .clr(cfg_wr), .pulse_in(frac_en), .limit(ps_val),
    .pulse_out(os_tick)
  );

  fbg_pulse_div #(.W(LATCH_W)) u_latch_div (
    .clk(clk), .rst(rst), .clr(cfg_wr), .pulse_in(os_tick), .limit(dl_value),
    .pulse_out(baud_tick)
  );
endmodule

// File: rtl/fbg_checker.sv
module fbg_checker
  import fbg_pkg::*;
#(
  parameter int DATA_W    = 32,
  parameter int ADDR_W    = 8,
  parameter int REG_SHIFT = 0,
  parameter int BASE_OFS  = 0
) (
  input logic              clk,
  input logic              rst,
  input logic              bus_wr,
  input logic              bus_rd,
  input logic [ADDR_W-1:0] bus_addr,
  input logic [DATA_W-1:0] bus_rdata,
  input logic              frac_en,
  input logic              os_tick,
  input logic              baud_tick,
  input logic              cfg_err
);
  logic mapped;
  assign mapped =
    (bus_addr == ADDR_W'(slot_addr(SLOT_PS,  REG_SHIFT, BASE_OFS))) ||
    (bus_addr == ADDR_W'(slot_addr(SLOT_MUL, REG_SHIFT, BASE_OFS))) ||
    (bus_addr == ADDR_W'(slot_addr(SLOT_DIV, REG_SHIFT, BASE_OFS)));

  // R5: a bad configuration silences the enable
  a_r5_err_silent: assert property (@(posedge clk) disable iff (rst)
    cfg_err |-> !frac_en);

  // R7: outputs are quiet right after a register write
  a_r7_write_clears: assert property (@(posedge clk) disable iff (rst)
    $past(bus_wr && mapped) |-> (!frac_en && !os_tick && !baud_tick));

  // R2: an oversample tick always follows an enable
  a_r2_os_after_frac: assert property (@(posedge clk) disable iff (rst)
    os_tick |-> $past(frac_en));

  // R2: a baud tick always follows an oversample tick
  a_r2_baud_after_os: assert property (@(posedge clk) disable iff (rst)
    baud_tick |-> $past(os_tick));

  // R9: unmapped reads return zero
  a_r9_unmapped_zero: assert property (@(posedge clk) disable iff (rst)
    $past(bus_rd && !mapped) |-> (bus_rdata == '0));
endmodule

bind frac_baud_gen fbg_checker #(
  .DATA_W(DATA_W), .ADDR_W(ADDR_W), .REG_SHIFT(REG_SHIFT), .BASE_OFS(BASE_OFS)
) u_fbg_checker (
  .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_addr(bus_addr),
  .bus_rdata(bus_rdata), .frac_en(frac_en), .os_tick(os_tick),
  .baud_tick(baud_tick), .cfg_err(cfg_err)
);

// File: tb/frac_baud_gen_bench.sv
module frac_baud_gen_bench;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        bus_wr = 1'b0, bus_rd = 1'b0;
  logic [7:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic [15:0] dl_value = 16'd16;
  logic        frac_en, os_tick, baud_tick, cfg_err;

  // second instance with scaled, offset addresses
  logic        s_rd = 1'b0;
  logic [7:0]  s_addr = '0;
  logic [31:0] s_rdata;
  logic        s_frac, s_os, s_baud, s_err;

  int vectors = 0;
  int fails   = 0;

  always #4 clk = ~clk;

  frac_baud_gen u_frac_baud_gen (
    .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .dl_value(dl_value),
    .frac_en(frac_en), .os_tick(os_tick), .baud_tick(baud_tick), .cfg_err(cfg_err)
  );

  frac_baud_gen #(.REG_SHIFT(1), .BASE_OFS(4)) u_frac_baud_gen_s (
    .clk(clk), .rst(rst), .bus_wr(1'b0), .bus_rd(s_rd), .bus_addr(s_addr),
    .bus_wdata(32'd0), .bus_rdata(s_rdata), .dl_value(16'd16),
    .frac_en(s_frac), .os_tick(s_os), .baud_tick(s_baud), .cfg_err(s_err)
  );

  typedef struct {
    string tag;
    int    cycles;
    int    e_frac;
    int    e_os;
    int    e_baud;
  } exp_t;

  exp_t exp_q[$];
  bit   mon_busy = 1'b0;

  task automatic check(string req, int act, int exp);
    vectors++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // monitor: pops expected window counts and compares pulse totals
  initial begin
    forever begin
      exp_t it;
      int cf, co, cb;
      wait (exp_q.size() > 0);
      it = exp_q.pop_front();
      mon_busy = 1'b1;
      cf = 0; co = 0; cb = 0;
      repeat (it.cycles) begin
        @(negedge clk);
        cf += int'(frac_en);
        co += int'(os_tick);
        cb += int'(baud_tick);
      end
      if (it.e_frac >= 0) check({it.tag, " frac_en count"}, cf, it.e_frac);
      if (it.e_os   >= 0) check({it.tag, " os_tick count"}, co, it.e_os);
      if (it.e_baud >= 0) check({it.tag, " baud_tick count"}, cb, it.e_baud);
      mon_busy = 1'b0;
    end
  end

  task automatic expect_window(string tag, int cycles, int ef, int eo, int eb);
    exp_t it;
    it.tag = tag; it.cycles = cycles; it.e_frac = ef; it.e_os = eo; it.e_baud = eb;
    exp_q.push_back(it);
    #1;
    wait (exp_q.size() == 0 && !mon_busy);
  endtask

  task automatic bus_write(logic [7:0] a, logic [31:0] d);
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic bus_read(logic [7:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_rd = 1'b1; bus_addr = a;
    @(negedge clk);
    bus_rd = 1'b0;
    d = bus_rdata;
  endtask

  task automatic summary();
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
  end

  initial begin
    logic [31:0] rd;

    repeat (4) @(negedge clk);
    check("R4 reset frac_en", int'(frac_en), 0);
    check("R4 reset os_tick", int'(os_tick), 0);
    check("R4 reset baud_tick", int'(baud_tick), 0);
    rst = 1'b0;

    // R4 / R3: reset values at the unscaled addresses
    bus_read(8'h30, rd); check("R4 prescale reset", int'(rd), 16);
    bus_read(8'h34, rd); check("R4 multiplier reset", int'(rd), 96);
    bus_read(8'h38, rd); check("R4 divisor reset", int'(rd), 125);
    check("R5 cfg_err low at defaults", int'(cfg_err), 0);

    // R1: 96 enables in every 125 cycles
    repeat (3) @(negedge clk);
    expect_window("R1 default ratio", 125, 96, -1, -1);
    // R2: full pattern period of 2000 cycles
    expect_window("R2 default chain", 2000, 1536, 96, 6);

    // R1: another ratio, 7 over 10
    bus_write(8'h34, 32'd7);
    bus_write(8'h38, 32'd10);
    repeat (3) @(negedge clk);
    expect_window("R1 ratio 7/10", 100, 70, -1, -1);

    // R6: multiplier equals divisor
    bus_write(8'h34, 32'd10);
    repeat (2) @(negedge clk);
    expect_window("R6 full rate", 50, 50, -1, -1);

    // R5: zero multiplier
    bus_write(8'h34, 32'd0);
    @(negedge clk);
    check("R5 cfg_err on zero multiplier", int'(cfg_err), 1);
    expect_window("R5 zero multiplier silent", 200, 0, 0, 0);
    // R5: multiplier above divisor
    bus_write(8'h34, 32'd11);
    @(negedge clk);
    check("R5 cfg_err on multiplier above divisor", int'(cfg_err), 1);
    expect_window("R5 oversize multiplier silent", 200, 0, 0, 0);
    bus_write(8'h34, 32'd96);
    bus_write(8'h38, 32'd125);
    @(negedge clk);
    check("R5 cfg_err clears", int'(cfg_err), 0);

    // R8: prescale 0 and latch 0 act as 1
    bus_write(8'h30, 32'd0);
    dl_value = 16'd0;
    repeat (5) @(negedge clk);
    expect_window("R8 zero prescale and latch", 125, 96, 96, 96);
    // R2: prescale 4, latch 2
    bus_write(8'h30, 32'd4);
    dl_value = 16'd2;
    repeat (5) @(negedge clk);
    expect_window("R2 prescale 4 latch 2", 125, 96, 24, 12);

    // R7: clear at several accumulator phases
    bus_write(8'h30, 32'd16);
    dl_value = 16'd16;
    for (int k = 0; k < 5; k++) begin
      repeat (k * 7 + 3) @(negedge clk);
      bus_write(8'h30, 32'd16);
      check("R7 outputs low after write", int'(frac_en | os_tick | baud_tick), 0);
      @(negedge clk);
      check("R7 enable low one cycle on", int'(frac_en), 0);
      @(negedge clk);
      check("R7 first enable two cycles after write", int'(frac_en), 1);
    end

    // R3: readback of written values
    bus_write(8'h34, 32'h0001_2345);
    bus_read(8'h34, rd); check("R3 multiplier readback", int'(rd), 32'h0001_2345);
    bus_write(8'h38, 32'h00AB_CDEF);
    bus_read(8'h38, rd); check("R3 divisor readback", int'(rd), 32'h00AB_CDEF);

    // R9: unmapped reads
    bus_read(8'h3C, rd); check("R9 read 0x3C", int'(rd), 0);
    bus_read(8'h31, rd); check("R9 read 0x31", int'(rd), 0);
    bus_read(8'h00, rd); check("R9 read 0x00", int'(rd), 0);

    // R3: scaled instance, shift 1 and base 4 -> 0x64, 0x6C, 0x74
    @(negedge clk); s_rd = 1'b1; s_addr = 8'h6C;
    @(negedge clk); s_rd = 1'b0;
    check("R3 scaled multiplier address", int'(s_rdata), 96);
    @(negedge clk); s_rd = 1'b1; s_addr = 8'h74;
    @(negedge clk); s_rd = 1'b0;
    check("R3 scaled divisor address", int'(s_rdata), 125);
    @(negedge clk); s_rd = 1'b1; s_addr = 8'h34;
    @(negedge clk); s_rd = 1'b0;
    check("R9 unscaled address on scaled instance", int'(s_rdata), 0);

    summary();
  end
endmodule